// File: doc/BRIEF.md
# Vectorised Compare-to-Predicate Unit

This block runs a branch-class compare over a run of register elements. Each element produces one bit in a predicate bitmask register. A start pulse supplies two source register bases, a vector flag for each source, an element count, a compare type, an integer/floating-point select and a predicate target index. In predicate form, the branch immediate field carries that target index.

The block walks the elements one per clock. A vector source reads consecutive registers from its base. A scalar source always supplies its base register, so its value is compared against every element of the vector source. If neither source is a vector, no predicate work is done, and a one-cycle scalar-branch pulse tells the pipeline to run an ordinary branch.

The operand register files and the predicate banks are small internal models. The operand files are loaded through a write port. Predicate registers are observed through a combinational read port.

Top module: `vcmp_pred_unit`

## Requirements
- R1: A start with at least one vector flag set runs the predicate form. A start with both flags clear pulses `scalar_br_o` high for exactly the cycle after the start edge, never raises `busy_o` or `done_o`, and leaves every predicate register unchanged.
- R2: A predicate-form start clears the target predicate register. When the compare for element i is true, bit i is set. All other bits, including those at or above the effective element count, read zero.
- R3: For element i, a vector source reads register (base + i) modulo NREGS, and a scalar source reads its base register. NREGS is a power of two.
- R4: When one source is scalar, its value is compared against every element of the other source, in either operand order.
- R5: The `cmp_op_i` encodings for integer compares are: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than, 5 unsigned greater-or-equal. Codes 6 and 7 are always false.
- R6: `fp_i`=1 selects the floating-point operand file and the floating-point predicate bank, and `fp_i`=0 selects the integer ones. The other bank is untouched. A floating-point compare uses raw bits: code 0 is bit-equality, code 1 is its inverse, and every other code is false.
- R7: For an effective count N≥1, `busy_o` is high for the N cycles after the start edge, and `done_o` is high for exactly the following cycle.
- R8: A predicate-form start with count 0 never raises `busy_o`. It pulses `done_o` in the cycle after the start edge and leaves the target register all zero.
- R9: A count above XLEN is clamped to XLEN elements.
- R10: `start_i` is ignored while `busy_o` is high. It does not change the timing, the target or any other predicate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when not busy) |
| src1_i | input | $clog2(NREGS) | First source base register |
| src2_i | input | $clog2(NREGS) | Second source base register |
| vec1_i | input | 1 | First source is a vector |
| vec2_i | input | 1 | Second source is a vector |
| vl_i | input | $clog2(XLEN+1)+1 | Requested element count |
| cmp_op_i | input | 3 | Compare type |
| fp_i | input | 1 | Floating-point file and bank select |
| pdst_i | input | $clog2(NPRED) | Predicate target index |
| busy_o | output | 1 | Elements being processed |
| done_o | output | 1 | One-cycle completion pulse |
| scalar_br_o | output | 1 | One-cycle pulse requesting a scalar branch |
| rf_we_i | input | 1 | Operand file write enable |
| rf_fp_i | input | 1 | Operand file select for the write |
| rf_waddr_i | input | $clog2(NREGS) | Operand write address |
| rf_wdata_i | input | XLEN | Operand write data |
| pred_fp_i | input | 1 | Predicate bank select for the read |
| pred_raddr_i | input | $clog2(NPRED) | Predicate read index |
| pred_rdata_o | output | XLEN | Predicate register contents |

## Verification
The embedded assertions check the handshake on every cycle:
- `done_o` is a single pulse and never coincides with `busy_o`.
- Every fall of `busy_o` is followed by `done_o`.
- The scalar-branch pulse stands alone.
- The element counter stays below the latched count.
- A predicate clear and a bit set never happen in the same cycle.

Only the bench's scenarios can show the following:
- the resulting bitmask values
- the addressing of vector and scalar operands, including wraparound
- bank separation between integer and floating point
- clamping of the element count
- that a second start is really ignored

To cover these, it compares the outputs against a behavioural model on every cycle and reads back predicate registers after each operation.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd2,
    CMP_GE  = 3'd3,
    CMP_LTU = 3'd4,
    CMP_GEU = 3'd5
  } cmp_op_e;
endpackage

// File: rtl/vcmp_regfile.sv
module vcmp_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic            wfp_i,
  input  logic [RW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            rfp_i,
  input  logic [RW-1:0]   raddr1_i,
  input  logic [RW-1:0]   raddr2_i,
  output logic [XLEN-1:0] rdata1_o,
  output logic [XLEN-1:0] rdata2_o
);
  logic [XLEN-1:0] mem_q [2][NREGS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wfp_i][waddr_i] <= wdata_i;
  end

  assign rdata1_o = mem_q[rfp_i][raddr1_i];
  assign rdata2_o = mem_q[rfp_i][raddr2_i];
endmodule

// File: rtl/vcmp_compare.sv
module vcmp_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      op_i,
  input  logic            fp_i,
  output logic            hit_o
);
  import vcmp_pkg::*;

  logic eq, lt_s, lt_u;
  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    hit_o = 1'b0;
    if (fp_i) begin
      // raw-bit equality only
      if (op_i == CMP_EQ) hit_o = eq;
      else if (op_i == CMP_NE) hit_o = !eq;
    end else begin
      case (op_i)
        CMP_EQ:  hit_o = eq;
        CMP_NE:  hit_o = !eq;
        CMP_LT:  hit_o = lt_s;
        CMP_GE:  hit_o = !lt_s;
        CMP_LTU: hit_o = lt_u;
        CMP_GEU: hit_o = !lt_u;
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vcmp_pred_bank.sv
module vcmp_pred_bank #(
  parameter int XLEN  = 32,
  parameter int NPRED = 8,
  localparam int PW   = $clog2(NPRED),
  localparam int BW   = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            set_i,
  input  logic            fp_i,
  input  logic [PW-1:0]   idx_i,
  input  logic [BW-1:0]   bit_i,
  input  logic            rfp_i,
  input  logic [PW-1:0]   ridx_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] preg_q [2][NPRED];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < NPRED; r++) preg_q[b][r] <= '0;
    end else if (clr_i) begin
      preg_q[fp_i][idx_i] <= '0;
    end else if (set_i) begin
      preg_q[fp_i][idx_i][bit_i] <= 1'b1;
    end
  end

  assign rdata_o = preg_q[rfp_i][ridx_i];

  // R2: clearing and setting never collide
  p_clr_set_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && set_i));
endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NPRED = 8,
  localparam int RW   = $clog2(NREGS),
  localparam int PW   = $clog2(NPRED),
  localparam int BW   = $clog2(XLEN),
  localparam int VLW  = $clog2(XLEN + 1) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [RW-1:0]   src1_i,
  input  logic [RW-1:0]   src2_i,
  input  logic            vec1_i,
  input  logic            vec2_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [2:0]      cmp_op_i,
  input  logic            fp_i,
  input  logic [PW-1:0]   pdst_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            scalar_br_o,
  input  logic            rf_we_i,
  input  logic            rf_fp_i,
  input  logic [RW-1:0]   rf_waddr_i,
  input  logic [XLEN-1:0] rf_wdata_i,
  input  logic            pred_fp_i,
  input  logic [PW-1:0]   pred_raddr_i,
  output logic [XLEN-1:0] pred_rdata_o
);
  localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);

  logic           busy_q, done_q, sbr_q;
  logic [VLW-1:0] cnt_q, vl_q;
  logic [RW-1:0]  src1_q, src2_q;
  logic           vec1_q, vec2_q, fp_q;
  logic [2:0]     op_q;
  logic [PW-1:0]  pdst_q;

  logic           accept, vec_mode, last, hit;
  logic [VLW-1:0] vl_eff;
  logic [RW-1:0]  addr1, addr2;
  logic [XLEN-1:0] opa, opb;

  assign accept   = start_i && !busy_q;
  assign vec_mode = vec1_i || vec2_i;
  assign vl_eff   = (vl_i > VL_MAX) ? VL_MAX : vl_i;
  assign last     = (cnt_q == vl_q - 1'b1);

  // NREGS power of two: truncation gives the wraparound
  assign addr1 = vec1_q ? src1_q + RW'(cnt_q) : src1_q;
  assign addr2 = vec2_q ? src2_q + RW'(cnt_q) : src2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sbr_q  <= 1'b0;
      cnt_q  <= '0;
      vl_q   <= '0;
      src1_q <= '0;
      src2_q <= '0;
      vec1_q <= 1'b0;
      vec2_q <= 1'b0;
      fp_q   <= 1'b0;
      op_q   <= '0;
      pdst_q <= '0;
    end else begin
      done_q <= 1'b0;
      sbr_q  <= 1'b0;
      if (accept) begin
        src1_q <= src1_i;
        src2_q <= src2_i;
        vec1_q <= vec1_i;
        vec2_q <= vec2_i;
        fp_q   <= fp_i;
        op_q   <= cmp_op_i;
        pdst_q <= pdst_i;
        vl_q   <= vl_eff;
        cnt_q  <= '0;
        if (!vec_mode)          sbr_q  <= 1'b1;
        else if (vl_eff == '0)  done_q <= 1'b1;
        else                    busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  vcmp_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk_i    (clk_i),
    .we_i     (rf_we_i),
    .wfp_i    (rf_fp_i),
    .waddr_i  (rf_waddr_i),
    .wdata_i  (rf_wdata_i),
    .rfp_i    (fp_q),
    .raddr1_i (addr1),
    .raddr2_i (addr2),
    .rdata1_o (opa),
    .rdata2_o (opb)
  );

  vcmp_compare #(.XLEN(XLEN)) u_cmp (
    .a_i   (opa),
    .b_i   (opb),
    .op_i  (op_q),
    .fp_i  (fp_q),
    .hit_o (hit)
  );

  vcmp_pred_bank #(.XLEN(XLEN), .NPRED(NPRED)) u_pred (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept && vec_mode),
    .set_i   (busy_q && hit),
    .fp_i    (busy_q ? fp_q : fp_i),
    .idx_i   (busy_q ? pdst_q : pdst_i),
    .bit_i   (cnt_q[BW-1:0]),
    .rfp_i   (pred_fp_i),
    .ridx_i  (pred_raddr_i),
    .rdata_o (pred_rdata_o)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign scalar_br_o = sbr_q;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_fall_then_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_scalar_alone_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scalar_br_o |-> (!busy_o && !done_o));
  p_cnt_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < vl_q && vl_q <= VL_MAX));
endmodule

// File: tb/vcmp_pred_unit_test.sv
module vcmp_pred_unit_test;
  localparam int XLEN = 32, NREGS = 32, NPRED = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, vec1 = 0, vec2 = 0, fp = 0;
  logic [4:0]  src1 = 0, src2 = 0;
  logic [6:0]  vl = 0;
  logic [2:0]  op = 0;
  logic [2:0]  pdst = 0;
  logic        rf_we = 0, rf_fp = 0, pred_fp = 0;
  logic [4:0]  rf_waddr = 0;
  logic [31:0] rf_wdata = 0;
  logic [2:0]  pred_raddr = 0;
  logic        busy, done, sbr;
  logic [31:0] pred_rdata;

  int errors = 0, checks = 0;
  logic [31:0] mrf [2][NREGS];
  logic [31:0] pm  [2][NPRED];

  vcmp_pred_unit #(.XLEN(XLEN), .NREGS(NREGS), .NPRED(NPRED)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src1_i(src1), .src2_i(src2),
    .vec1_i(vec1), .vec2_i(vec2), .vl_i(vl), .cmp_op_i(op), .fp_i(fp),
    .pdst_i(pdst), .busy_o(busy), .done_o(done), .scalar_br_o(sbr),
    .rf_we_i(rf_we), .rf_fp_i(rf_fp), .rf_waddr_i(rf_waddr), .rf_wdata_i(rf_wdata),
    .pred_fp_i(pred_fp), .pred_raddr_i(pred_raddr), .pred_rdata_o(pred_rdata));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mcmp(logic [31:0] a, logic [31:0] b, int o, bit f);
    if (f) return (o == 0) ? (a == b) : (o == 1) ? (a != b) : 1'b0;
    case (o)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return $signed(a) >= $signed(b);
      4: return a < b;
      5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic rd_pred(string tag, bit f, int idx);
    pred_fp = f; pred_raddr = idx[2:0];
    #1;
    check(tag, pred_rdata, pm[f][idx]);
  endtask

  // alt >= 0: hold start and retarget during busy (must be ignored)
  task automatic run_op(string tag, int s1, int s2, bit v1, bit v2, int vlen,
                        int o, bit f, int pd, int alt);
    int n = (vlen > XLEN) ? XLEN : vlen;
    bit vm = v1 || v2;
    if (vm) begin
      logic [31:0] e = '0;
      for (int i = 0; i < n; i++) begin
        logic [31:0] a = v1 ? mrf[f][(s1 + i) % NREGS] : mrf[f][s1];
        logic [31:0] b = v2 ? mrf[f][(s2 + i) % NREGS] : mrf[f][s2];
        if (mcmp(a, b, o, f)) e[i] = 1'b1;
      end
      pm[f][pd] = e;
    end
    @(negedge clk);
    start = 1; src1 = s1[4:0]; src2 = s2[4:0]; vec1 = v1; vec2 = v2;
    vl = vlen[6:0]; op = o[2:0]; fp = f; pdst = pd[2:0];
    for (int k = 1; k <= n + 2; k++) begin
      @(negedge clk);
      check({tag, " busy R7"}, {31'd0, busy}, {31'd0, vm && k <= n});
      check({tag, " done R7/R8"}, {31'd0, done}, {31'd0, vm && k == n + 1});
      check({tag, " scalar R1"}, {31'd0, sbr}, {31'd0, !vm && k == 1});
      if (k == 1 && alt >= 0) begin
        pdst = alt[2:0]; src1 = 5'd9; vec1 = 1; vec2 = 1; vl = 7'd3;
      end else start = 0;
    end
    start = 0;
    rd_pred({tag, " pred R2"}, f, pd);
    rd_pred({tag, " other bank R6"}, !f, pd);
    if (alt >= 0) rd_pred({tag, " retarget ignored R10"}, f, alt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < NPRED; r++) pm[b][r] = '0;
    for (int r = 0; r < NREGS; r++) begin
      mrf[0][r] = 32'((r % 5) - 2);
      mrf[1][r] = (r % 3 == 0) ? 32'hbf80_0000 : 32'h3f80_0000;
    end
    mrf[0][31] = 32'h7fff_ffff;
    mrf[0][7]  = 32'h8000_0000;
    mrf[1][4]  = 32'h7fc0_0000;
    repeat (2) @(negedge clk);
    // reset state
    check("reset busy R7", {31'd0, busy}, 32'd0);
    check("reset done R7", {31'd0, done}, 32'd0);
    check("reset scalar R1", {31'd0, sbr}, 32'd0);
    rst_n = 1;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < NREGS; r++) begin
        @(negedge clk);
        rf_we = 1; rf_fp = b[0]; rf_waddr = r[4:0]; rf_wdata = mrf[b][r];
      end
    @(negedge clk); rf_we = 0;
    rd_pred("reset pred R2", 0, 3);

    // R5: every compare code, vector-vector
    for (int o = 0; o < 8; o++)
      run_op("R5 op", 0, 5, 1, 1, 10, o, 0, o, -1);
    // R4: vector vs scalar, both orders
    run_op("R4 vec-scalar", 2, 3, 1, 0, 12, 2, 0, 1, -1);
    run_op("R4 scalar-vec", 3, 2, 0, 1, 12, 2, 0, 2, -1);
    // R3: base + i wraps modulo NREGS
    run_op("R3 wrap", 28, 1, 1, 1, 8, 4, 0, 3, -1);
    // R1: both scalar, target unchanged
    run_op("R1 scalar", 0, 5, 0, 0, 10, 0, 0, 3, -1);
    // R8: zero count clears a populated target
    run_op("R8 vl0", 0, 5, 1, 0, 0, 1, 0, 3, -1);
    // R9: count clamped
    run_op("R9 clamp", 0, 1, 1, 1, 40, 1, 0, 4, -1);
    run_op("R9 exact", 0, 0, 1, 0, 32, 3, 0, 5, -1);
    // R2: shorter rerun leaves upper bits zero
    run_op("R2 shrink", 0, 1, 1, 1, 5, 1, 0, 4, -1);
    // R6: floating-point file and bank
    run_op("R6 fp eq", 0, 3, 1, 0, 9, 0, 1, 1, -1);
    run_op("R6 fp ne", 1, 4, 1, 1, 9, 1, 1, 2, -1);
    run_op("R6 fp lt", 0, 1, 1, 1, 9, 2, 1, 1, -1);
    // R10: start during busy ignored
    run_op("R10 ignore", 0, 2, 1, 1, 6, 2, 0, 6, 7);
    run_op("R10 ignore", 1, 2, 1, 0, 6, 1, 0, 7, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule